// File: doc/BRIEF.md
# Board Interrupt and Status Register Bank

This block sits on a board-control register port and collects sixteen external, level-sensitive interrupt lines. Each line passes through a two-flop synchronizer; a synchronized line that is high while its enable bit is set latches a sticky pending bit. The single interrupt output to the host is high whenever any pending bit has its enable bit set. Pending bits stay set after the line drops and clear only when the host rewrites the pending register.

The bank also holds two card-slot status words. The card-detect bit of each word follows one interrupt line, and the host may change only the slot's power and reset control field. Eight plain 32-bit scratch and control registers for LEDs, switches and general board control complete the map. Offsets are decoded over a 1 MiB window.

The register port has no back-pressure. A write lands at the clock edge where `reg_wr` is sampled. A read request is accepted at every edge where `reg_rd` is high, and its data appears on `reg_rdata` with `reg_rvalid` high for one cycle after that edge.

Top module: `board_irq_regbank`

## Requirements
- R1: After reset, both slot words read 0x00000420 (ready bit 10 and card-detect bit 5 set). Every other register reads zero, and `irq_out` and `reg_rvalid` are low.
- R2: The plain registers at offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90 each read back exactly the last 32-bit value written to them.
- R3: A write to the enable register (offset 0xC0) stores the written value ANDed with 0x000FEEFF.
- R4: A write to the pending register (offset 0xD0) replaces its contents with the written value ANDed with 0x000FEEFF. This is the only way a pending bit is cleared, and it takes precedence over input setting in the same cycle.
- R5: Pending bit n (n in 0..15) is set at each edge where synchronized line n is high and enable bit n is set. A line that is high while its enable bit is clear sets nothing, and a line going low leaves the pending bit set.
- R6: `irq_out` equals the OR of (pending AND enable). It follows a register write on the cycle after the write edge. It rises three clock edges after an enabled line rises at the input pin.
- R7: Line 9 drives bit 5 of the slot word at 0xE0, and line 13 drives bit 5 of the slot word at 0xE4. The bit is 0 while the synchronized line is high and 1 while it is low, and it is updated one edge after the synchronizer output.
- R8: A write to either slot word changes only its bits [4:0]. Bit 10 stays 1, and bit 5 and all other bits keep their values.
- R9: Reads of any unmapped offset (including unaligned ones) return zero, and writes to an unmapped offset change no register.
- R10: `reg_rvalid` is high in exactly the cycle after each accepted read request, together with the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | External level interrupt lines, asynchronous |
| reg_addr | input | 20 | Byte offset within the 1 MiB window |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read request |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after the request |
| irq_out | output | 1 | Level interrupt to the host |

## Verification
A wrong pending or enable bit shows on `irq_out` within one cycle, because the output is plain logic over those two registers. It also shows on the next read of 0xD0 or 0xC0. A lost synchronizer stage, or an extra one, moves the rise of `irq_out` away from the third edge after the pin changes, so the bench checks both the second and the third edge. A corrupted slot word shows on the next read of 0xE0 or 0xE4, either in the detect bit three edges after the line moves or in the bits a write was not allowed to touch.

// File: rtl/board_regs_pkg.sv
package board_regs_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 20;
  localparam int unsigned N_LINES  = 16;
  localparam logic [31:0] IRQ_IMPL = 32'h000F_EEFF;

  localparam int unsigned N_PLAIN = 8;
  localparam logic [31:0] PLAIN_OFS [N_PLAIN] = '{
    32'h10, 32'h14, 32'h40, 32'h60, 32'h80, 32'h84, 32'h88, 32'h90};

  localparam logic [31:0] OFS_IRQ_EN   = 32'hC0;
  localparam logic [31:0] OFS_IRQ_PEND = 32'hD0;

  localparam int unsigned N_SLOTS = 2;
  localparam logic [31:0] SLOT_OFS  [N_SLOTS] = '{32'hE0, 32'hE4};
  localparam int unsigned SLOT_LINE [N_SLOTS] = '{9, 13};
  localparam int unsigned SLOT_CTL_W = 5;
  localparam int unsigned SLOT_DET   = 5;
  localparam int unsigned SLOT_RDY   = 10;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      sync_out <= '0;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int unsigned W    = 32,
  parameter int unsigned N    = 16,
  parameter logic [31:0] IMPL = 32'h000F_EEFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic         en_wr,
  input  logic         pend_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q,
  output logic [W-1:0] pend_q,
  output logic         irq_out
);
  localparam logic [W-1:0] IMPL_W = IMPL[W-1:0];

  logic [W-1:0] lvl_wide;
  assign lvl_wide = {{(W-N){1'b0}}, lvl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_wr) en_q <= wdata & IMPL_W;
      if (pend_wr) pend_q <= wdata & IMPL_W;
      else         pend_q <= pend_q | (lvl_wide & en_q & IMPL_W);
    end
  end

  assign irq_out = |(pend_q & en_q);

  // R3
  en_impl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~IMPL_W) == '0);
  // R4
  pend_impl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~IMPL_W) == '0);
  // R5
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_wr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
  // R5
  pend_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_wr && (($past(pend_q) | (lvl_wide & en_q)) == $past(pend_q)) && (lvl_wide & en_q) == '0)
      |=> ((pend_q & ~$past(pend_q)) == '0));
  // R6
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (en_q != '0));
endmodule

// File: rtl/slot_status.sv
module slot_status #(
  parameter int unsigned W     = 32,
  parameter int unsigned CTL_W = 5,
  parameter int unsigned DET   = 5,
  parameter int unsigned RDY   = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         det_line,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] word
);
  logic [CTL_W-1:0] ctl_q;
  logic             det_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      det_n_q <= 1'b1;
    end else begin
      if (wr) ctl_q <= wdata[CTL_W-1:0];
      det_n_q <= ~det_line;
    end
  end

  always_comb begin
    word           = '0;
    word[CTL_W-1:0] = ctl_q;
    word[DET]      = det_n_q;
    word[RDY]      = 1'b1;
  end

  // R8
  slot_ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(ctl_q));
  // R7
  slot_det_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_line) |=> !word[DET]);
  // R7
  slot_det_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(det_line) |=> word[DET]);
endmodule

// File: rtl/board_irq_regbank.sv
module board_irq_regbank
  import board_regs_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NL = N_LINES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] irq_in,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          reg_rd,
  output logic [DW-1:0] reg_rdata,
  output logic          reg_rvalid,
  output logic          irq_out
);
  logic [NL-1:0] lvl;
  logic [DW-1:0] en_q, pend_q;
  logic [DW-1:0] plain_q [N_PLAIN];
  logic [DW-1:0] slot_word [N_SLOTS];
  logic          hit_en, hit_pend;
  logic [DW-1:0] rd_mux;

  irq_sync #(.W(NL)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(irq_in), .sync_out(lvl));

  assign hit_en   = (reg_addr == OFS_IRQ_EN[AW-1:0]);
  assign hit_pend = (reg_addr == OFS_IRQ_PEND[AW-1:0]);

  irq_pend #(.W(DW), .N(NL), .IMPL(IRQ_IMPL)) pend_i (
    .clk(clk), .rst_n(rst_n), .lvl(lvl),
    .en_wr(reg_wr && hit_en), .pend_wr(reg_wr && hit_pend),
    .wdata(reg_wdata), .en_q(en_q), .pend_q(pend_q), .irq_out(irq_out));

  for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) plain_q[g] <= '0;
      else if (reg_wr && reg_addr == PLAIN_OFS[g][AW-1:0]) plain_q[g] <= reg_wdata;
    end
  end

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    slot_status #(.W(DW), .CTL_W(SLOT_CTL_W), .DET(SLOT_DET), .RDY(SLOT_RDY)) slot_i (
      .clk(clk), .rst_n(rst_n), .det_line(lvl[SLOT_LINE[s]]),
      .wr(reg_wr && reg_addr == SLOT_OFS[s][AW-1:0]),
      .wdata(reg_wdata), .word(slot_word[s]));
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_PLAIN; i++)
      if (reg_addr == PLAIN_OFS[i][AW-1:0]) rd_mux = plain_q[i];
    for (int i = 0; i < N_SLOTS; i++)
      if (reg_addr == SLOT_OFS[i][AW-1:0]) rd_mux = slot_word[i];
    if (hit_en)   rd_mux = en_q;
    if (hit_pend) rd_mux = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  // R10
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);
  // R10
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);
  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr[1:0] != 2'b00) |=> (reg_rdata == '0));
endmodule

// File: tb/board_irq_regbank_tb_top.sv
module board_irq_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic [19:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  board_irq_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .irq_out(irq_out));

  // {addr, write data, expected read-back}
  localparam int NV = 17;
  localparam logic [83:0] VEC [NV] = '{
    {20'h00010, 32'hA5A5_0001, 32'hA5A5_0001},
    {20'h00014, 32'h1234_5678, 32'h1234_5678},
    {20'h00040, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {20'h00060, 32'h0000_00C3, 32'h0000_00C3},
    {20'h00080, 32'h8000_0000, 32'h8000_0000},
    {20'h00084, 32'h0F0F_F0F0, 32'h0F0F_F0F0},
    {20'h00088, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {20'h00090, 32'h0000_5A5A, 32'h0000_5A5A},
    {20'h000C0, 32'hFFFF_FFFF, 32'h000F_EEFF},
    {20'h000D0, 32'hFFFF_FFFF, 32'h000F_EEFF},
    {20'h000D0, 32'h0000_1100, 32'h0000_0000},
    {20'h000C0, 32'h0000_0000, 32'h0000_0000},
    {20'h000E0, 32'hFFFF_FFFF, 32'h0000_043F},
    {20'h000E4, 32'h0000_0012, 32'h0000_0432},
    {20'h00011, 32'hFFFF_FFFF, 32'h0000_0000},
    {20'h000D4, 32'hFFFF_FFFF, 32'h0000_0000},
    {20'hFFFFC, 32'h1357_9BDF, 32'h0000_0000}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [19:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq_out", {31'b0, irq_out}, 32'h0);
    check("R1 rvalid", {31'b0, reg_rvalid}, 32'h0);
    for (int i = 0; i < 12; i++) begin
      rd(VEC[i][83:64], v);
      check("R1 reset value", v, 32'h0);
    end
    rd(20'hE0, v); check("R1 slot0 reset", v, 32'h0000_0420);
    rd(20'hE4, v); check("R1 slot1 reset", v, 32'h0000_0420);

    // R2 R3 R4 R8 R9: table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][83:64], VEC[i][63:32]);
      rd(VEC[i][83:64], v);
      check("R2/R3/R4/R8/R9 table", v, VEC[i][31:0]);
    end
    // R9: unmapped writes left plain registers intact
    rd(20'h10, v); check("R9 plain kept", v, 32'hA5A5_0001);
    rd(20'h90, v); check("R9 plain kept", v, 32'h0000_5A5A);

    // R10 rvalid pulse
    @(negedge clk); reg_addr = 20'h14; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
    check("R10 rvalid high", {31'b0, reg_rvalid}, 32'h1);
    check("R10 rdata", reg_rdata, 32'h1234_5678);
    @(negedge clk);
    check("R10 rvalid low", {31'b0, reg_rvalid}, 32'h0);

    // R5: line high with enable clear sets nothing
    irq_in[3] = 1'b1;
    repeat (5) @(negedge clk);
    rd(20'hD0, v); check("R5 masked line", v, 32'h0);
    check("R6 irq low masked", {31'b0, irq_out}, 32'h0);
    wr(20'hC0, 32'h0000_0008);
    @(negedge clk);
    rd(20'hD0, v); check("R5 latch when enabled", v, 32'h8);
    check("R6 irq high", {31'b0, irq_out}, 32'h1);
    irq_in[3] = 1'b0;
    repeat (5) @(negedge clk);
    rd(20'hD0, v); check("R5 sticky after drop", v, 32'h8);
    wr(20'hD0, 32'h0);
    check("R4 R6 irq cleared next cycle", {31'b0, irq_out}, 32'h0);
    rd(20'hD0, v); check("R4 pend cleared", v, 32'h0);

    // R6 input latency: third edge
    wr(20'hC0, 32'h0000_0020);
    @(negedge clk); irq_in[5] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R6 not at edge 2", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    check("R6 high at edge 3", {31'b0, irq_out}, 32'h1);
    wr(20'hC0, 32'h0);
    check("R6 mask drop", {31'b0, irq_out}, 32'h0);
    wr(20'hC0, 32'h0000_0020);
    check("R6 mask restore", {31'b0, irq_out}, 32'h1);
    irq_in[5] = 1'b0;
    wr(20'hC0, 32'h0);
    wr(20'hD0, 32'h0);

    // R7 card detect
    irq_in[9] = 1'b1;
    repeat (4) @(negedge clk);
    rd(20'hE0, v); check("R7 slot0 card in", v, 32'h0000_041F);
    rd(20'hE4, v); check("R7 slot1 untouched", v, 32'h0000_0432);
    irq_in[13] = 1'b1;
    repeat (4) @(negedge clk);
    rd(20'hE4, v); check("R7 slot1 card in", v, 32'h0000_0412);
    // R8: write cannot set detect or clear ready
    wr(20'hE4, 32'h0000_0000);
    rd(20'hE4, v); check("R8 slot1 protected", v, 32'h0000_0400);
    irq_in[9] = 1'b0;
    repeat (4) @(negedge clk);
    rd(20'hE0, v); check("R7 slot0 card out", v, 32'h0000_043F);

    done = 1'b1;
    report();
  end
endmodule